// File: doc/BRIEF.md
# Multi-Chip Neuron Evaluation Sequencer

This block steps one chip through a frame of 256 neuron evaluations, always in index order, and keeps several chips in lock-step while it does so. All chips share one ready line that is open-drain, so the line reads high only when no chip holds it low. Each chip holds the line low while its current evaluation runs. A chip starts the next evaluation only when its clear-to-start input is high. In a multi-chip system that input is the shared line. In a single-chip system it is the chip's own line or a constant high.

The evaluation itself happens outside the block. A start pulse and the current index go out, and a done pulse comes back together with the result bit. That bit is driven on the serial output, and it is valid from the cycle the ready line is released. A start-of-frame flag marks the first evaluation of each frame.

Each chip also samples four neighbour serial inputs and one external serial input when clear-to-start falls. Each sample goes into a 256x1 bit memory for that input, at the index of the evaluation that completed most recently. A combinational read port makes all five memories visible at once.

Top module: `neuron_frame_seq`

## Requirements
- R1: An active-low synchronous reset sets the evaluation index to 0 and clears `rdy_pull_o`, `sof_o`, `sout_o` and `eval_start_o`.
- R2: An evaluation starts only while the idle sequencer sees clear-to-start high after its two-flop synchronizer. While `cts_i` is held low, no start pulse appears and `rdy_pull_o` stays 0.
- R3: A start makes `eval_start_o` high for exactly one cycle, on the same edge that sets `rdy_pull_o` to 1 (pull the line low). `rdy_pull_o` then stays 1 until the evaluation completes.
- R4: When `eval_done_i` is high during an evaluation, the next edge clears `rdy_pull_o` and loads `eval_bit_i` into `sout_o`. When `eval_done_i` arrives while no evaluation runs, nothing changes.
- R5: `eval_idx_o` holds the index of the running or next evaluation. It advances by one on each completion and wraps from 255 to 0, so the frames run 0,1,...,255,0,...
- R6: `sof_o` goes high on the start of evaluation 0 and low on its completion. It is 0 during every other evaluation.
- R7: On each falling edge of the synchronized clear-to-start, if a completion has not yet been captured, the block stores `nbr_i[0..3]` and `ext_i` at the index of that completed evaluation. Each completion is captured once.
- R8: `rd_data_o[j]` is the bit stored at `rd_addr_i` for input j. Bits 0 to 3 are the neighbour inputs `nbr_i[0..3]` and bit 4 is `ext_i`. The read is combinational.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cts_i | input | 1 | Clear-to-start, asynchronous, active high |
| eval_done_i | input | 1 | Completion pulse from the evaluation stub |
| eval_bit_i | input | 1 | Result bit of the completing evaluation |
| nbr_i | input | 4 | Neighbour serial inputs |
| ext_i | input | 1 | External serial input |
| rd_addr_i | input | 8 | Read address of the bit memories |
| rdy_pull_o | output | 1 | Output enable of the open-drain ready line (1 = pull low) |
| eval_start_o | output | 1 | One-cycle start pulse for the evaluation |
| eval_idx_o | output | 8 | Current evaluation index |
| sof_o | output | 1 | Start-of-frame flag |
| sout_o | output | 1 | Serial output bit of the last completed evaluation |
| rd_data_o | output | 5 | Stored bits at rd_addr_i, one per input |

## Verification
The bench runs a full frame and then goes into the next one, so the 255-to-0 wrap and the second rise of `sof_o` are both exercised. A sequencer that forgot to wrap, or that held the flag high for the whole frame, would show a wrong index or a wrong flag at the start check. After each sampling edge the bench scrambles the serial inputs, so a design that sampled on the level, on the rising edge, or at the index being started would read back the wrong bit. Two cases test what the block must ignore. First, a peer holds clear-to-start low, and a sequencer that did not honour it would start anyway. Second, a stray done pulse arrives while the block is idle, and a sequencer that did not check its state would change the serial bit or the index.

// File: rtl/nfs_pkg.sv
// Package: types shared by the neuron frame sequencer modules.
package nfs_pkg;
    // Sequencer state: waiting for clear-to-start, or evaluation running.
    typedef enum logic {
        ST_WAIT = 1'b0,
        ST_BUSY = 1'b1
    } seq_state_t;
endpackage

// File: rtl/cts_sync_edge.sv
// Module: cts_sync_edge
// Brings the asynchronous clear-to-start into the clock domain through a
// chain of STAGES flops. Gives the synchronized level, plus a one-cycle
// falling-edge strobe found as "registered high, current low".
// Assumes: STAGES >= 2; the input holds each level for longer than a cycle.
module cts_sync_edge #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_i,
    output logic level_o,
    output logic fall_o
);
    logic [STAGES-1:0] chain;
    logic              level_q;

    // Shift the async input through the synchronizer chain.
    always_ff @(posedge clk) begin
        if (!rst_n) chain <= '0;
        else        chain <= {chain[STAGES-2:0], async_i};
    end

    // Keep the previous synchronized level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) level_q <= 1'b0;
        else        level_q <= chain[STAGES-1];
    end

    // Expose the level and the falling-edge strobe.
    always_comb begin
        level_o = chain[STAGES-1];
        fall_o  = level_q & ~chain[STAGES-1];
    end
endmodule

// File: rtl/seq_ctrl.sv
// Module: seq_ctrl
// Evaluation sequencer. Waits for synchronized clear-to-start, starts the
// evaluation at the current index, holds the ready line low until the done
// pulse, then releases it, latches the result bit and advances the index
// (wrapping at N_EVAL). Remembers the completed index until the next
// clear-to-start falling edge captures the serial inputs for it.
// Assumes: an evaluation takes at least STAGES+1 cycles, so the line's low
// level reaches the synchronizer before release.
module seq_ctrl
    import nfs_pkg::*;
#(
    parameter int N_EVAL = 256,
    parameter int IDX_W  = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cts_level_i,
    input  logic             cts_fall_i,
    input  logic             done_i,
    input  logic             bit_i,
    output logic             pull_o,
    output logic             start_o,
    output logic             sof_o,
    output logic             sout_o,
    output logic [IDX_W-1:0] idx_o,
    output logic             cap_we_o,
    output logic [IDX_W-1:0] cap_addr_o
);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(N_EVAL - 1);

    seq_state_t state;
    logic       pending;

    // Main sequencing: start on clear-to-start, finish on done.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state      <= ST_WAIT;
            idx_o      <= '0;
            start_o    <= 1'b0;
            sof_o      <= 1'b0;
            sout_o     <= 1'b0;
            cap_addr_o <= '0;
        end else begin
            start_o <= 1'b0;
            case (state)
                ST_WAIT: begin
                    if (cts_level_i) begin
                        state   <= ST_BUSY;
                        start_o <= 1'b1;
                        sof_o   <= (idx_o == '0);
                    end
                end
                ST_BUSY: begin
                    if (done_i) begin
                        state      <= ST_WAIT;
                        sof_o      <= 1'b0;
                        sout_o     <= bit_i;
                        cap_addr_o <= idx_o;
                        idx_o      <= (idx_o == LAST_IDX) ? '0 : idx_o + 1'b1;
                    end
                end
                default: state <= ST_WAIT;
            endcase
        end
    end

    // Track a completion whose serial inputs are not yet captured.
    always_ff @(posedge clk) begin
        if (!rst_n)                          pending <= 1'b0;
        else if (state == ST_BUSY && done_i) pending <= 1'b1;
        else if (cts_fall_i)                 pending <= 1'b0;
    end

    // Ready-line enable follows the busy state; capture on a pending fall.
    always_comb begin
        pull_o   = (state == ST_BUSY);
        cap_we_o = cts_fall_i & pending;
    end
endmodule

// File: rtl/bit_store.sv
// Module: bit_store
// DEPTH x 1 bit memory with one synchronous write port and one
// combinational read port. Contents are not reset.
// Assumes: waddr and raddr are below DEPTH.
module bit_store #(
    parameter int DEPTH = 256,
    parameter int AW    = 8
) (
    input  logic          clk,
    input  logic          we_i,
    input  logic [AW-1:0] waddr_i,
    input  logic          wdata_i,
    input  logic [AW-1:0] raddr_i,
    output logic          rdata_o
);
    logic mem [DEPTH];

    // Write the captured bit.
    always_ff @(posedge clk) begin
        if (we_i) mem[waddr_i] <= wdata_i;
    end

    // Combinational read.
    always_comb rdata_o = mem[raddr_i];
endmodule

// File: rtl/neuron_frame_seq.sv
// Module: neuron_frame_seq (top)
// Sequences N_EVAL neuron evaluations per frame under a wired-AND ready /
// clear-to-start handshake with peer chips. Drives the start-of-frame flag
// and serial output bit, and captures N_NBR neighbour inputs plus one
// external input into per-input bit memories on clear-to-start falling edges.
// Assumes: evaluation time of at least SYNC_STAGES+1 cycles.
module neuron_frame_seq #(
    parameter int N_EVAL      = 256,
    parameter int N_NBR       = 4,
    parameter int SYNC_STAGES = 2,
    localparam int IDX_W      = $clog2(N_EVAL),
    localparam int N_IN       = N_NBR + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cts_i,
    input  logic             eval_done_i,
    input  logic             eval_bit_i,
    input  logic [N_NBR-1:0] nbr_i,
    input  logic             ext_i,
    input  logic [IDX_W-1:0] rd_addr_i,
    output logic             rdy_pull_o,
    output logic             eval_start_o,
    output logic [IDX_W-1:0] eval_idx_o,
    output logic             sof_o,
    output logic             sout_o,
    output logic [N_IN-1:0]  rd_data_o
);
    logic             cts_level;
    logic             cts_fall;
    logic             cap_we;
    logic [IDX_W-1:0] cap_addr;
    logic [N_IN-1:0]  cap_bits;

    // Gather the serial inputs: neighbours low, external on top.
    always_comb cap_bits = {ext_i, nbr_i};

    cts_sync_edge #(.STAGES(SYNC_STAGES)) sync_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (cts_i),
        .level_o (cts_level),
        .fall_o  (cts_fall)
    );

    seq_ctrl #(.N_EVAL(N_EVAL), .IDX_W(IDX_W)) ctrl_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .cts_level_i (cts_level),
        .cts_fall_i  (cts_fall),
        .done_i      (eval_done_i),
        .bit_i       (eval_bit_i),
        .pull_o      (rdy_pull_o),
        .start_o     (eval_start_o),
        .sof_o       (sof_o),
        .sout_o      (sout_o),
        .idx_o       (eval_idx_o),
        .cap_we_o    (cap_we),
        .cap_addr_o  (cap_addr)
    );

    for (genvar g = 0; g < N_IN; g++) begin : g_store
        bit_store #(.DEPTH(N_EVAL), .AW(IDX_W)) store_i (
            .clk     (clk),
            .we_i    (cap_we),
            .waddr_i (cap_addr),
            .wdata_i (cap_bits[g]),
            .raddr_i (rd_addr_i),
            .rdata_o (rd_data_o[g])
        );
    end
endmodule

// File: rtl/nfs_checker.sv
// Module: nfs_checker
// Protocol properties of neuron_frame_seq, bound to the top module.
module nfs_checker #(
    parameter int IDX_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             eval_start_o,
    input logic             rdy_pull_o,
    input logic             eval_done_i,
    input logic [IDX_W-1:0] eval_idx_o,
    input logic             sof_o,
    input logic             cts_level,
    input logic             cts_fall,
    input logic             cap_we
);
    p_start_needs_cts_r2: assert property (@(posedge clk) disable iff (!rst_n)
        eval_start_o |-> $past(cts_level));
    p_start_from_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
        eval_start_o |-> !$past(rdy_pull_o));
    p_start_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
        eval_start_o |=> !eval_start_o);
    p_start_pulls_r3: assert property (@(posedge clk) disable iff (!rst_n)
        eval_start_o |-> rdy_pull_o);
    p_hold_pull_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (rdy_pull_o && !eval_done_i) |=> rdy_pull_o);
    p_release_on_done_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (rdy_pull_o && eval_done_i) |=> !rdy_pull_o);
    p_idx_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (rdy_pull_o && eval_done_i) |=> (eval_idx_o == IDX_W'($past(eval_idx_o) + 1'b1)));
    p_idx_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !(rdy_pull_o && eval_done_i) |=> $stable(eval_idx_o));
    p_sof_first_r6: assert property (@(posedge clk) disable iff (!rst_n)
        sof_o |-> (eval_idx_o == '0) && rdy_pull_o);
    p_sof_rise_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sof_o) |-> eval_start_o);
    p_cap_on_fall_r7: assert property (@(posedge clk) disable iff (!rst_n)
        cap_we |-> cts_fall);
endmodule

bind neuron_frame_seq nfs_checker #(.IDX_W(IDX_W)) chk_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .eval_start_o (eval_start_o),
    .rdy_pull_o   (rdy_pull_o),
    .eval_done_i  (eval_done_i),
    .eval_idx_o   (eval_idx_o),
    .sof_o        (sof_o),
    .cts_level    (cts_level),
    .cts_fall     (cts_fall),
    .cap_we       (cap_we)
);

// File: tb/neuron_frame_seq_tb_top.sv
// Bench for neuron_frame_seq: single chip with clear-to-start tied to its own
// ready line, plus a peer hold that can keep the line low.
module neuron_frame_seq_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int N_EVAL     = 256;
    localparam int WATCHDOG   = 200000;

    // Vector table: {result bit, serial input pattern[4:0], delay[3:0]}.
    localparam logic [9:0] VEC [8] = '{
        {1'b1, 5'b10101, 4'd6},
        {1'b0, 5'b01110, 4'd7},
        {1'b1, 5'b11001, 4'd9},
        {1'b1, 5'b00011, 4'd6},
        {1'b0, 5'b11111, 4'd12},
        {1'b0, 5'b00000, 4'd8},
        {1'b1, 5'b10010, 4'd10},
        {1'b0, 5'b01001, 4'd13}
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cts_i;
    logic       eval_done_i = 1'b0;
    logic       eval_bit_i = 1'b0;
    logic [3:0] nbr_i = '0;
    logic       ext_i = 1'b0;
    logic [7:0] rd_addr_i = '0;
    logic       rdy_pull_o, eval_start_o, sof_o, sout_o;
    logic [7:0] eval_idx_o;
    logic [4:0] rd_data_o;
    logic       peer_hold = 1'b0;
    int         n_chk = 0;
    int         n_bad = 0;

    assign cts_i = ~(rdy_pull_o | peer_hold);

    always #(CLK_PERIOD/2) clk = ~clk;

    neuron_frame_seq dut_i (
        .clk(clk), .rst_n(rst_n), .cts_i(cts_i), .eval_done_i(eval_done_i),
        .eval_bit_i(eval_bit_i), .nbr_i(nbr_i), .ext_i(ext_i),
        .rd_addr_i(rd_addr_i), .rdy_pull_o(rdy_pull_o),
        .eval_start_o(eval_start_o), .eval_idx_o(eval_idx_o), .sof_o(sof_o),
        .sout_o(sout_o), .rd_data_o(rd_data_o)
    );

    function automatic logic exp_bit(input logic [7:0] k);
        return VEC[k[2:0]][9] ^ k[3];
    endfunction
    function automatic logic [4:0] exp_pat(input logic [7:0] k);
        return VEC[k[2:0]][8:4] ^ k[7:3];
    endfunction
    function automatic int exp_dly(input logic [7:0] k);
        return int'(VEC[k[2:0]][3:0]);
    endfunction

    task automatic chk(input logic ok, input string req, input string what,
                       input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic report();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    // Evaluation stub: answers each start pulse after the table delay.
    initial begin
        forever begin
            @(negedge clk);
            if (eval_start_o) begin
                logic [7:0] sk;
                sk = eval_idx_o;
                repeat (exp_dly(sk) - 1) @(negedge clk);
                eval_bit_i  = exp_bit(sk);
                eval_done_i = 1'b1;
                @(negedge clk);
                eval_done_i = 1'b0;
            end
        end
    end

    // Watchdog: an expired run counts as a failed check.
    initial begin
        repeat (WATCHDOG) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual %0d expected %0d", WATCHDOG, 0);
        report();
    end

    initial begin
        logic [7:0] k;
        logic       sout_hold;
        // R1: state held under reset.
        repeat (3) @(negedge clk);
        chk(rdy_pull_o == 1'b0, "R1", "rdy_pull_o in reset", int'(rdy_pull_o), 0);
        chk(sof_o == 1'b0, "R1", "sof_o in reset", int'(sof_o), 0);
        chk(eval_idx_o == 8'd0, "R1", "eval_idx_o in reset", int'(eval_idx_o), 0);
        chk(eval_start_o == 1'b0 && sout_o == 1'b0, "R1", "start/sout in reset",
            int'({eval_start_o, sout_o}), 0);
        rst_n = 1'b1;

        // Table-driven frame: 256 evaluations plus the first of the next frame.
        for (int e = 0; e <= N_EVAL; e++) begin
            k = 8'(e);
            do @(negedge clk); while (!eval_start_o);
            chk(eval_idx_o == k, "R5", "index at start", int'(eval_idx_o), int'(k));
            chk(sof_o == (k == 8'd0), "R6", "sof at start", int'(sof_o), int'(k == 8'd0));
            chk(rdy_pull_o == 1'b1, "R3", "line pulled at start", int'(rdy_pull_o), 1);
            @(negedge clk);
            chk(eval_start_o == 1'b0, "R3", "start pulse width", int'(eval_start_o), 0);
            repeat (3) @(negedge clk);
            // R7: scramble inputs after the sampling edge.
            {ext_i, nbr_i} = ~exp_pat(k - 8'd1);
            chk(rdy_pull_o == 1'b1, "R3", "line held while busy", int'(rdy_pull_o), 1);
            do @(negedge clk); while (rdy_pull_o);
            chk(sout_o == exp_bit(k), "R4", "serial bit at release", int'(sout_o), int'(exp_bit(k)));
            chk(sof_o == 1'b0, "R6", "sof after completion", int'(sof_o), 0);
            chk(eval_idx_o == k + 8'd1, "R5", "index after completion",
                int'(eval_idx_o), int'(k + 8'd1));
            {ext_i, nbr_i} = exp_pat(k);
            if (e == N_EVAL) peer_hold = 1'b1;
        end

        // R2: a peer keeps clear-to-start low; R4: stray done while idle.
        sout_hold = sout_o;
        repeat (3) @(negedge clk);
        eval_bit_i  = ~sout_hold;
        eval_done_i = 1'b1;
        @(negedge clk);
        eval_done_i = 1'b0;
        for (int c = 0; c < 20; c++) begin
            @(negedge clk);
            chk(eval_start_o == 1'b0 && rdy_pull_o == 1'b0, "R2", "no start while held",
                int'({eval_start_o, rdy_pull_o}), 0);
        end
        chk(sout_o == sout_hold, "R4", "idle done ignored (sout)", int'(sout_o), int'(sout_hold));
        chk(eval_idx_o == 8'd1, "R4", "idle done ignored (index)", int'(eval_idx_o), 1);

        // R7/R8: read back the captured bits of the whole frame.
        for (int a = 0; a < N_EVAL; a++) begin
            rd_addr_i = 8'(a);
            #1;
            chk(rd_data_o == exp_pat(8'(a)), "R8", $sformatf("capture at %0d (R7)", a),
                int'(rd_data_o), int'(exp_pat(8'(a))));
        end

        // R2: release the peer, the next evaluation must follow.
        peer_hold = 1'b0;
        do @(negedge clk); while (!eval_start_o);
        chk(eval_idx_o == 8'd1 && sof_o == 1'b0, "R6", "second evaluation after hold",
            int'({sof_o, eval_idx_o}), 1);

        // R1: reset during a running evaluation.
        rst_n = 1'b0;
        @(negedge clk);
        chk(rdy_pull_o == 1'b0 && eval_idx_o == 8'd0 && sof_o == 1'b0, "R1",
            "reset while busy", int'({rdy_pull_o, sof_o, eval_idx_o}), 0);
        report();
    end
endmodule